// File: doc/BRIEF.md
# Two-Event Rendezvous With Abort

This block is a small synchronous reactive controller that joins two independent event streams. Each branch waits for its own single-cycle event pulse (`evt_a` or `evt_b`). The events may come in either order, several cycles apart, or in the same cycle. When both branches have seen their event, the block raises `join_pulse` for exactly one cycle. The pulse is combinational: it appears in the same cycle as the event that completes the pair.

An abort pulse (`abort_in`) ends the current round at once. Any remembered event is forgotten, and any event that arrives in the abort cycle is also thrown away. The block then waits again from the start. Once a round has produced its pulse, further events have no effect until the next abort. The behaviour then repeats, so each abort-delimited round can produce at most one pulse. A synchronous reset (`rst`) puts the block in the waiting state with nothing remembered and the pulse low.

Top module: `rendezvous_join`

## Requirements
- R1: While `rst` is high at a clock edge, `join_pulse` is low in that cycle. After reset no event is remembered, so a lone `evt_a` produces no pulse.
- R2: If `evt_a` arrives and `evt_b` arrives in a later cycle with no abort in between, `join_pulse` is high in the cycle of `evt_b` and only then.
- R3: If `evt_b` arrives first and `evt_a` arrives in a later cycle with no abort in between, `join_pulse` is high in the cycle of `evt_a`.
- R4: If `evt_a` and `evt_b` are both high in one cycle with `abort_in` low, and no pulse has yet been given in the round, `join_pulse` is high in that same cycle.
- R5: `join_pulse` never stays high for two consecutive cycles. After a pulse, further `evt_a`/`evt_b` events produce no pulse until an abort.
- R6: An abort makes the block forget any event that was remembered before it. After `evt_a`, then `abort_in`, then `evt_b`, there is no pulse.
- R7: When `abort_in` is high, `join_pulse` is low in that cycle, even if the event that completes the pair arrives in the same cycle.
- R8: An event that arrives in the same cycle as `abort_in` does not count toward the new round.
- R9: After an abort, a new pair of events produces a pulse again. This holds whether or not the previous round had fired.
- R10: `rst` takes precedence over events: `evt_a` and `evt_b` together during reset produce no pulse and are not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| evt_a | input | 1 | Event pulse for branch A |
| evt_b | input | 1 | Event pulse for branch B |
| abort_in | input | 1 | Abort pulse, which restarts the round |
| join_pulse | output | 1 | One-cycle pulse when both events are seen in a round |

## Verification
The hardest situations to reach are the coincidences:
- an abort in the same cycle as the completing event;
- an event in the same cycle as an abort, followed by its partner;
- events arriving after the round has already fired.

Each needs a specific ordering of three inputs across several cycles. The bench therefore sweeps every sequence of four input vectors, with each vector drawn from all eight combinations of the two events and the abort, and a reset before each sequence. This places every such coincidence against every possible remembered state. Expected pulses come from a small arithmetic model of the round kept in the bench.

// File: rtl/rdv_pkg.sv
package rdv_pkg;

  localparam int unsigned RDV_BRANCHES = 2;

  typedef logic [RDV_BRANCHES-1:0] branch_vec_t;

  typedef enum logic {
    PH_WAIT = 1'b0,
    PH_DONE = 1'b1
  } phase_t;

  // every branch is armed (seen earlier or arriving now)
  function automatic logic all_armed(input branch_vec_t armed);
    return &armed;
  endfunction

  // a round may complete only while waiting and not preempted
  function automatic logic may_fire(input logic rst, input logic abort,
                                    input phase_t ph, input branch_vec_t armed);
    return !rst && !abort && (ph == PH_WAIT) && all_armed(armed);
  endfunction

endpackage

// File: rtl/rdv_branch.sv
module rdv_branch (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic hold,
  input  logic evt,
  output logic seen,
  output logic armed
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen <= 1'b0;
    end else if (!hold && evt) begin
      seen <= 1'b1;
    end
  end

  assign armed = seen | evt;

endmodule

// File: rtl/rdv_ctrl.sv
module rdv_ctrl
  import rdv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        abort,
  input  branch_vec_t armed_vec,
  output logic        fire,
  output logic        phase_done,
  output logic        hold,
  output logic        clear
);

  phase_t phase_q;

  assign fire       = may_fire(rst, abort, phase_q, armed_vec);
  assign phase_done = (phase_q == PH_DONE);
  assign hold       = phase_done | abort;
  assign clear      = abort | fire;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      phase_q <= PH_WAIT;
    end else if (fire) begin
      phase_q <= PH_DONE;
    end
  end

endmodule

// File: rtl/rendezvous_join.sv
module rendezvous_join
  import rdv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evt_a,
  input  logic evt_b,
  input  logic abort_in,
  output logic join_pulse
);

  branch_vec_t evt_vec;
  branch_vec_t seen_vec;
  branch_vec_t armed_vec;
  logic        fire;
  logic        phase_done;
  logic        hold;
  logic        clear;

  assign evt_vec = {evt_b, evt_a};

  for (genvar g = 0; g < RDV_BRANCHES; g++) begin : g_branch
    rdv_branch u_branch (
      .clk   (clk),
      .rst   (rst),
      .clear (clear),
      .hold  (hold),
      .evt   (evt_vec[g]),
      .seen  (seen_vec[g]),
      .armed (armed_vec[g])
    );
  end

  rdv_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .abort      (abort_in),
    .armed_vec  (armed_vec),
    .fire       (fire),
    .phase_done (phase_done),
    .hold       (hold),
    .clear      (clear)
  );

  assign join_pulse = fire;

endmodule

// File: rtl/rendezvous_join_chk.sv
module rendezvous_join_chk
  import rdv_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        evt_a,
  input logic        evt_b,
  input logic        abort_in,
  input logic        join_pulse,
  input logic        phase_done,
  input branch_vec_t seen_vec
);

  assert_rst_quiet_R1: assert property (@(posedge clk) rst |-> !join_pulse);

  assert_rst_forgets_R10: assert property (@(posedge clk)
    rst |=> (seen_vec == '0 && !phase_done));

  assert_needs_event_R2: assert property (@(posedge clk) disable iff (rst)
    join_pulse |-> (evt_a || evt_b));

  assert_single_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    join_pulse |=> !join_pulse);

  assert_done_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    phase_done |-> !join_pulse);

  assert_abort_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    abort_in |-> !join_pulse);

  assert_abort_forgets_R6: assert property (@(posedge clk) disable iff (rst)
    abort_in |=> (seen_vec == '0 && !phase_done));

endmodule

bind rendezvous_join rendezvous_join_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_a      (evt_a),
  .evt_b      (evt_b),
  .abort_in   (abort_in),
  .join_pulse (join_pulse),
  .phase_done (phase_done),
  .seen_vec   (seen_vec)
);

// File: tb/rendezvous_join_test.sv
`timescale 1ns/100ps
module rendezvous_join_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_a = 1'b0;
  logic evt_b = 1'b0;
  logic abort_in = 1'b0;
  logic join_pulse;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rendezvous_join uut (
    .clk        (clk),
    .rst        (rst),
    .evt_a      (evt_a),
    .evt_b      (evt_b),
    .abort_in   (abort_in),
    .join_pulse (join_pulse)
  );

  // drive on the falling edge, check the combinational pulse, then pass the rising edge
  task automatic step(input bit rs, input bit a, input bit b, input bit r,
                      input bit exp, input string tag);
    @(negedge clk);
    rst = rs; evt_a = a; evt_b = b; abort_in = r;
    #1;
    checks++;
    if (join_pulse !== exp) begin
      fails++;
      $display("FAIL %s: join_pulse=%0b expected=%0b at %0t", tag, join_pulse, exp, $time);
    end
    @(posedge clk);
  endtask

  function automatic string sweep_tag(input bit rs, input bit a, input bit b,
                                      input bit r, input bit done);
    if (rs) return "R10";
    if (r) return (a || b) ? "R8" : "R7";
    if (done) return "R5";
    if (a && b) return "R4";
    return "R2";
  endfunction

  initial begin
    // R1 reset state
    step(1, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, "R1");
    step(0, 1, 0, 0, 0, "R1");
    // R2 A then B
    step(1, 0, 0, 0, 0, "R1");
    step(0, 1, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, "R2");
    step(0, 0, 1, 0, 1, "R2");
    step(0, 1, 1, 0, 0, "R5");
    step(0, 0, 1, 0, 0, "R5");
    // R9 new round after abort
    step(0, 0, 0, 1, 0, "R9");
    // R3 B then A
    step(0, 0, 1, 0, 0, "R3");
    step(0, 1, 0, 0, 1, "R3");
    step(0, 0, 0, 1, 0, "R9");
    // R4 same cycle
    step(0, 1, 1, 0, 1, "R4");
    step(0, 0, 0, 1, 0, "R9");
    // R6 abort forgets
    step(0, 1, 0, 0, 0, "R6");
    step(0, 0, 0, 1, 0, "R6");
    step(0, 0, 1, 0, 0, "R6");
    step(0, 1, 0, 0, 1, "R9");
    step(0, 0, 0, 1, 0, "R9");
    // R7 abort with completing event
    step(0, 1, 0, 0, 0, "R7");
    step(0, 0, 1, 1, 0, "R7");
    step(0, 1, 0, 0, 0, "R8");
    step(0, 0, 1, 0, 1, "R9");
    step(0, 0, 0, 1, 0, "R9");
    // R8 event in abort cycle is discarded
    step(0, 1, 0, 1, 0, "R8");
    step(0, 0, 1, 0, 0, "R8");
    step(0, 1, 0, 0, 1, "R8");
    // R10 reset beats events
    step(1, 1, 1, 0, 0, "R10");
    step(0, 0, 0, 0, 0, "R10");
    step(0, 1, 0, 0, 0, "R10");
    step(0, 0, 1, 0, 1, "R10");

    // exhaustive sweep over four-cycle sequences of (a, b, abort)
    for (int seq = 0; seq < 4096; seq++) begin
      bit ma = 0, mb = 0, done = 0;
      step(1, 0, 0, 0, 0, "R1");
      for (int k = 0; k < 4; k++) begin
        int v = (seq >> (3 * k)) & 7;
        bit a = v[0];
        bit b = v[1];
        bit r = v[2];
        int armed = int'(ma | a) + int'(mb | b);
        bit exp = (armed == 2) && !r && !done;
        step(0, a, b, r, exp, sweep_tag(0, a, b, r, done));
        if (r) begin
          ma = 0; mb = 0; done = 0;
        end else if (exp) begin
          ma = 0; mb = 0; done = 1;
        end else if (!done) begin
          ma = ma | a; mb = mb | b;
        end
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule